// File: doc/BRIEF.md
# Cluster Remote-Subblock Attraction Buffer

This block sits in one cluster of a clustered processor whose first-level data cache is word-interleaved across the clusters. It lies between the cluster's memory unit and the port into the interleaved cache. Word addresses are interleaved on their low bits. Bits [CL_W-1:0] name the home cluster, where CL_W = log2(CLUSTERS). Bit CL_W selects one of the two words that a home module stores together as a subblock; for example, words 3 and 7 share a home when there are four clusters. The buffer keeps copies of subblocks whose home is another cluster. A strided loop that keeps touching the same remote subblock is then served locally after the first fetch.

Accesses whose home is the local cluster pass straight through. A remote load that hits returns in one cycle and is marked as served by the buffer. A remote load that misses fetches the whole subblock and allocates it in round-robin order. Before that, a dirty victim is written back. A remote store that hits updates the copy and marks it dirty. A remote store that misses is written through and is not allocated. A flush command, issued when a loop ends, empties the buffer. It visits one entry per cycle and writes back the dirty ones.

Both data paths use valid/ready. A request is taken on a cycle where valid and ready are both high. Once valid is raised, the payload holds steady until it is taken. `up_req_ready` is high only while the block is idle and no flush is being requested. Only one access is in flight at a time. Loads give exactly one response. Stores give none. The downstream response has no ready: the block always waits for it.

Top module: `cluster_attract_buf`

## Requirements
- R1: After reset the buffer holds no entries, `up_req_ready` is high, and `up_rsp_valid`, `dn_req_valid` and `flush_done` are low.
- R2: An access whose home field `addr[CL_W-1:0]` equals LOCAL_ID is forwarded downstream every time. A load becomes a read (kind 0). A store becomes a write (kind 1, word in the low half of `dn_req_wdata`). Nothing is allocated, and `up_rsp_from_buf` is 0.
- R3: A remote load miss issues one downstream read. It returns the word of `dn_rsp_data` picked by address bit CL_W (0 = low half, 1 = high half), with `up_rsp_from_buf` = 0.
- R4: A remote load hit to either word of a held subblock makes no downstream request. Its response is valid in the cycle after acceptance, with `up_rsp_from_buf` = 1.
- R5: A remote store hit updates the held word with no downstream traffic. Later loads return the new value.
- R6: A remote store miss is written through as one kind-1 request and allocates nothing, so the next load of that address misses.
- R7: Allocation uses a round-robin pointer over the ENTRIES slots. With 8 entries, the ninth distinct subblock evicts the first one allocated.
- R8: When the victim is dirty, a write-back (kind 2) is issued before the read. It carries the subblock base address (bit CL_W cleared), word 0 in the low half and word 1 in the high half.
- R9: A flush visits every entry, writes back each dirty one, and leaves all entries invalid. With no downstream stall, `flush_done` pulses for one cycle ENTRIES clock edges after the edge that samples `flush_start`.
- R10: `flush_start` takes priority over a request in the same cycle: `up_req_ready` stays low and the request is not taken.
- R11: Under back-pressure, `up_rsp_*` and `dn_req_*` hold steady until taken, and results are unchanged.
- R12: A subblock is held in at most one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Memory-unit request valid |
| up_req_ready | output | 1 | Request accepted when high with valid |
| up_req_wr | input | 1 | 1 = store, 0 = load |
| up_req_addr | input | ADDR_W | Word address |
| up_req_wdata | input | DATA_W | Store data |
| up_rsp_valid | output | 1 | Load response valid |
| up_rsp_ready | input | 1 | Memory unit takes the response |
| up_rsp_data | output | DATA_W | Load data |
| up_rsp_from_buf | output | 1 | 1 when served by the buffer |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream takes the request |
| dn_req_kind | output | 2 | 0 read, 1 write-through, 2 write-back |
| dn_req_addr | output | ADDR_W | Word address or subblock base |
| dn_req_wdata | output | 2*DATA_W | Write data (word 1 high, word 0 low) |
| dn_rsp_valid | input | 1 | Read data returned (one cycle) |
| dn_rsp_data | input | 2*DATA_W | Whole subblock, word 1 high |
| flush_start | input | 1 | Start a flush (sampled when idle) |
| flush_done | output | 1 | One-cycle pulse at flush end |

## Verification
Loads are tried to both words of one remote subblock, to the local home, and to addresses already written. This separates true hits from bypass and from stale copies. A run of nine distinct remote subblocks, the first of them dirty, shows whether the round-robin victim choice and the write-back ordering are right. Stores that hit and stores that miss are told apart by downstream traffic counts and by whether the next load hits. Flushes with and without downstream back-pressure check timing, write-back contents and invalidation. A held-off response checks stability.

// File: rtl/attr_buf_pkg.sv
package attr_buf_pkg;
  typedef enum logic [1:0] {
    DN_RD = 2'd0,
    DN_WR = 2'd1,
    DN_WB = 2'd2
  } dn_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RSP,
    S_VWB,
    S_DNREQ,
    S_WAIT,
    S_FLUSH
  } ab_state_e;
endpackage

// File: rtl/ab_addr_map.sv
module ab_addr_map #(
  parameter int ADDR_W   = 16,
  parameter int CL_W     = 2,
  parameter int LOCAL_ID = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-2:0] tag,
  output logic              sel,
  output logic              remote
);
  localparam logic [CL_W-1:0] LID = CL_W'(LOCAL_ID);

  // tag = block bits above the word select, joined with the home field
  assign tag    = {addr[ADDR_W-1:CL_W+1], addr[CL_W-1:0]};
  assign sel    = addr[CL_W];
  assign remote = (addr[CL_W-1:0] != LID);
endmodule

// File: rtl/ab_rr_ptr.sv
module ab_rr_ptr #(
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  output logic [$clog2(ENTRIES)-1:0] ptr
);
  localparam int IDX_W = $clog2(ENTRIES);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (adv) ptr <= (ptr == IDX_W'(ENTRIES-1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/ab_entries.sv
module ab_entries #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 15,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TAG_W-1:0]           lk_tag,
  output logic                       lk_hit,
  output logic [$clog2(ENTRIES)-1:0] lk_idx,
  output logic [2*DATA_W-1:0]        lk_data,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic                       rd_valid,
  output logic                       rd_dirty,
  output logic [TAG_W-1:0]           rd_tag,
  output logic [2*DATA_W-1:0]        rd_data,
  input  logic                       fill_en,
  input  logic [$clog2(ENTRIES)-1:0] fill_idx,
  input  logic [TAG_W-1:0]           fill_tag,
  input  logic [2*DATA_W-1:0]        fill_data,
  input  logic                       st_en,
  input  logic [$clog2(ENTRIES)-1:0] st_idx,
  input  logic                       st_sel,
  input  logic [DATA_W-1:0]          st_word,
  input  logic                       clr_en,
  input  logic [$clog2(ENTRIES)-1:0] clr_idx
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld, drt, match;
  logic [TAG_W-1:0]    tags  [ENTRIES];
  logic [2*DATA_W-1:0] words [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic                v_q, d_q;
    logic [TAG_W-1:0]    t_q;
    logic [2*DATA_W-1:0] w_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        t_q <= '0;
        w_q <= '0;
      end else if (clr_en && clr_idx == IDX_W'(i)) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (fill_en && fill_idx == IDX_W'(i)) begin
        v_q <= 1'b1;
        d_q <= 1'b0;
        t_q <= fill_tag;
        w_q <= fill_data;
      end else if (st_en && st_idx == IDX_W'(i)) begin
        d_q <= 1'b1;
        if (st_sel) w_q[2*DATA_W-1:DATA_W] <= st_word;
        else        w_q[DATA_W-1:0]        <= st_word;
      end
    end

    assign vld[i]   = v_q;
    assign drt[i]   = d_q;
    assign tags[i]  = t_q;
    assign words[i] = w_q;
    assign match[i] = v_q && (t_q == lk_tag);
  end

  always_comb begin
    lk_idx  = '0;
    lk_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_idx  = IDX_W'(i);
        lk_data = words[i];
      end
    end
  end

  assign lk_hit   = |match;
  assign rd_valid = vld[rd_idx];
  assign rd_dirty = drt[rd_idx];
  assign rd_tag   = tags[rd_idx];
  assign rd_data  = words[rd_idx];

  // R12
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/cluster_attract_buf.sv
module cluster_attract_buf #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int ENTRIES  = 8,
  parameter int CLUSTERS = 4,
  parameter int LOCAL_ID = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_req_valid,
  output logic                up_req_ready,
  input  logic                up_req_wr,
  input  logic [ADDR_W-1:0]   up_req_addr,
  input  logic [DATA_W-1:0]   up_req_wdata,
  output logic                up_rsp_valid,
  input  logic                up_rsp_ready,
  output logic [DATA_W-1:0]   up_rsp_data,
  output logic                up_rsp_from_buf,
  output logic                dn_req_valid,
  input  logic                dn_req_ready,
  output logic [1:0]          dn_req_kind,
  output logic [ADDR_W-1:0]   dn_req_addr,
  output logic [2*DATA_W-1:0] dn_req_wdata,
  input  logic                dn_rsp_valid,
  input  logic [2*DATA_W-1:0] dn_rsp_data,
  input  logic                flush_start,
  output logic                flush_done
);
  import attr_buf_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CL_W  = $clog2(CLUSTERS);
  localparam int TAG_W = ADDR_W - 1;

  ab_state_e state;
  logic              req_wr;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [IDX_W-1:0]  fidx;

  logic [TAG_W-1:0]    up_tag, req_tag, rd_tag;
  logic                up_sel, up_remote, req_sel, req_remote;
  logic                lk_hit, rd_valid, rd_dirty;
  logic [IDX_W-1:0]    lk_idx, vic_ptr, rd_idx;
  logic [2*DATA_W-1:0] lk_data, rd_data;
  logic acc, fill_en, st_en, clr_en, ld_hit;

  ab_addr_map #(.ADDR_W(ADDR_W), .CL_W(CL_W), .LOCAL_ID(LOCAL_ID)) u_map_up (
    .addr(up_req_addr), .tag(up_tag), .sel(up_sel), .remote(up_remote));

  ab_addr_map #(.ADDR_W(ADDR_W), .CL_W(CL_W), .LOCAL_ID(LOCAL_ID)) u_map_req (
    .addr(req_addr), .tag(req_tag), .sel(req_sel), .remote(req_remote));

  ab_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(fill_en), .ptr(vic_ptr));

  ab_entries #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ent (
    .clk(clk), .rst_n(rst_n),
    .lk_tag(up_tag), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_data(lk_data),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .rd_tag(rd_tag), .rd_data(rd_data),
    .fill_en(fill_en), .fill_idx(vic_ptr), .fill_tag(req_tag), .fill_data(dn_rsp_data),
    .st_en(st_en), .st_idx(lk_idx), .st_sel(up_sel), .st_word(up_req_wdata),
    .clr_en(clr_en), .clr_idx(fidx));

  assign up_req_ready = (state == S_IDLE) && !flush_start;
  assign acc          = up_req_valid && up_req_ready;
  assign ld_hit       = acc && !up_req_wr && up_remote && lk_hit;
  assign st_en        = acc && up_req_wr && up_remote && lk_hit;
  assign fill_en      = (state == S_WAIT) && dn_rsp_valid && req_remote;
  assign rd_idx       = (state == S_FLUSH) ? fidx : vic_ptr;
  assign up_rsp_valid = (state == S_RSP);

  always_comb begin
    dn_req_valid = 1'b0;
    dn_req_kind  = DN_WB;
    dn_req_addr  = {rd_tag[TAG_W-1:CL_W], 1'b0, rd_tag[CL_W-1:0]};
    dn_req_wdata = rd_data;
    case (state)
      S_VWB:   dn_req_valid = 1'b1;
      S_FLUSH: dn_req_valid = rd_valid && rd_dirty;
      S_DNREQ: begin
        dn_req_valid = 1'b1;
        dn_req_kind  = req_wr ? DN_WR : DN_RD;
        dn_req_addr  = req_addr;
        dn_req_wdata = {{DATA_W{1'b0}}, req_wdata};
      end
      default: ;
    endcase
  end

  assign clr_en = (state == S_FLUSH) && (!dn_req_valid || dn_req_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= S_IDLE;
      req_wr          <= 1'b0;
      req_addr        <= '0;
      req_wdata       <= '0;
      fidx            <= '0;
      up_rsp_data     <= '0;
      up_rsp_from_buf <= 1'b0;
      flush_done      <= 1'b0;
    end else begin
      flush_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (flush_start) begin
            state <= S_FLUSH;
            fidx  <= '0;
          end else if (ld_hit) begin
            up_rsp_data     <= up_sel ? lk_data[2*DATA_W-1:DATA_W] : lk_data[DATA_W-1:0];
            up_rsp_from_buf <= 1'b1;
            state           <= S_RSP;
          end else if (acc && !st_en) begin
            req_wr    <= up_req_wr;
            req_addr  <= up_req_addr;
            req_wdata <= up_req_wdata;
            if (!up_req_wr && up_remote && rd_valid && rd_dirty) state <= S_VWB;
            else                                                  state <= S_DNREQ;
          end
        end
        S_VWB:   if (dn_req_ready) state <= S_DNREQ;
        S_DNREQ: if (dn_req_ready) state <= req_wr ? S_IDLE : S_WAIT;
        S_WAIT: begin
          if (dn_rsp_valid) begin
            up_rsp_data     <= req_sel ? dn_rsp_data[2*DATA_W-1:DATA_W]
                                       : dn_rsp_data[DATA_W-1:0];
            up_rsp_from_buf <= 1'b0;
            state           <= S_RSP;
          end
        end
        S_RSP:   if (up_rsp_ready) state <= S_IDLE;
        S_FLUSH: begin
          if (clr_en) begin
            if (fidx == IDX_W'(ENTRIES-1)) begin
              state      <= S_IDLE;
              flush_done <= 1'b1;
            end else begin
              fidx <= fidx + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid && !up_rsp_ready |=> up_rsp_valid && $stable(up_rsp_data)
                                      && $stable(up_rsp_from_buf));
  // R11
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_kind)
                                      && $stable(dn_req_addr) && $stable(dn_req_wdata));
  // R4
  hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |=> up_rsp_valid && up_rsp_from_buf);
  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !up_remote |=> dn_req_valid && dn_req_addr == $past(up_req_addr));
  // R6
  st_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && up_req_wr && !(up_remote && lk_hit) |=> dn_req_valid && dn_req_kind == 2'd1);
  // R9
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);
endmodule

// File: tb/cluster_attract_buf_test.sv
`timescale 1ns/1ps
module cluster_attract_buf_test;
  logic clk = 1'b0;
  logic rst_n;
  logic up_req_valid, up_req_ready, up_req_wr;
  logic [15:0] up_req_addr;
  logic [31:0] up_req_wdata;
  logic up_rsp_valid, up_rsp_ready, up_rsp_from_buf;
  logic [31:0] up_rsp_data;
  logic dn_req_valid, dn_req_ready;
  logic [1:0] dn_req_kind;
  logic [15:0] dn_req_addr;
  logic [63:0] dn_req_wdata;
  logic dn_rsp_valid;
  logic [63:0] dn_rsp_data;
  logic flush_start, flush_done;

  always #2 clk = ~clk;

  cluster_attract_buf uut (
    .clk(clk), .rst_n(rst_n),
    .up_req_valid(up_req_valid), .up_req_ready(up_req_ready), .up_req_wr(up_req_wr),
    .up_req_addr(up_req_addr), .up_req_wdata(up_req_wdata),
    .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready),
    .up_rsp_data(up_rsp_data), .up_rsp_from_buf(up_rsp_from_buf),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_req_kind(dn_req_kind),
    .dn_req_addr(dn_req_addr), .dn_req_wdata(dn_req_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_data(dn_rsp_data),
    .flush_start(flush_start), .flush_done(flush_done));

  int total = 0, bad = 0;
  int n_rd = 0, n_wr = 0, n_wb = 0;
  bit bp = 1'b0, pend = 1'b0;
  logic [63:0] pdata;
  logic [31:0] mem [256];
  logic [31:0] sw  [256];
  logic [15:0] last_wb_addr = '0;
  logic [63:0] last_wb_data = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // downstream model: decides ready at each negedge, handshake at next posedge
  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'hA000_0000 + 32'(i);
      sw[i]  = 32'hA000_0000 + 32'(i);
    end
    dn_req_ready = 1'b1;
    dn_rsp_valid = 1'b0;
    dn_rsp_data  = '0;
    forever begin
      logic [7:0] b;
      @(negedge clk);
      dn_rsp_valid = pend;
      dn_rsp_data  = pdata;
      pend = 1'b0;
      dn_req_ready = bp ? ~dn_req_ready : 1'b1;
      if (rst_n && dn_req_valid && dn_req_ready) begin
        b = dn_req_addr[7:0] & 8'hFB;
        case (dn_req_kind)
          2'd0: begin n_rd++; pend = 1'b1; pdata = {mem[b | 8'd4], mem[b]}; end
          2'd1: begin n_wr++; mem[dn_req_addr[7:0]] = dn_req_wdata[31:0]; end
          default: begin
            n_wb++;
            last_wb_addr = dn_req_addr;
            last_wb_data = dn_req_wdata;
            mem[b] = dn_req_wdata[31:0];
            mem[b | 8'd4] = dn_req_wdata[63:32];
          end
        endcase
      end
    end
  end

  task automatic do_op(input bit wr, input logic [15:0] a, input logic [31:0] wd,
                       input int hold, output logic [31:0] rdat, output bit fb,
                       output int lat);
    @(negedge clk);
    up_req_valid = 1'b1; up_req_wr = wr; up_req_addr = a; up_req_wdata = wd;
    up_rsp_ready = (hold == 0);
    #1;
    while (!up_req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    up_req_valid = 1'b0;
    lat = 1; rdat = '0; fb = 1'b0;
    if (!wr) begin
      while (!up_rsp_valid) begin @(negedge clk); lat++; end
      rdat = up_rsp_data;
      fb   = up_rsp_from_buf;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk(up_rsp_valid && up_rsp_data == rdat, "R11", "held response",
            {31'd0, up_rsp_valid, up_rsp_data}, {32'd1, rdat});
      end
      up_rsp_ready = 1'b1;
      @(posedge clk);
    end
  endtask

  task automatic run_flush(output int edges);
    @(negedge clk);
    flush_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flush_start = 1'b0;
    edges = 0;
    while (!flush_done && edges < 1000) begin @(negedge clk); edges++; end
  endtask

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [31:0] wd;
    logic        fb;
    logic [1:0]  drd, dwr, dwb;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 16'd3,  32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd3},  // R3 first remote miss
    '{1'b0, 16'd7,  32'h0,         1'b1, 2'd0, 2'd0, 2'd0, 4'd4},  // R4 other word of subblock
    '{1'b0, 16'd3,  32'h0,         1'b1, 2'd0, 2'd0, 2'd0, 4'd4},  // R4
    '{1'b0, 16'd0,  32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd2},  // R2 local load
    '{1'b0, 16'd0,  32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd2},  // R2 not allocated
    '{1'b1, 16'd4,  32'h1111_0004, 1'b0, 2'd0, 2'd1, 2'd0, 4'd2},  // R2 local store
    '{1'b0, 16'd4,  32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd2},  // R2
    '{1'b1, 16'd7,  32'h2222_0007, 1'b0, 2'd0, 2'd0, 2'd0, 4'd5},  // R5 store hit
    '{1'b0, 16'd7,  32'h0,         1'b1, 2'd0, 2'd0, 2'd0, 4'd5},  // R5 reads new word
    '{1'b1, 16'd11, 32'h3333_000B, 1'b0, 2'd0, 2'd1, 2'd0, 4'd6},  // R6 store miss
    '{1'b0, 16'd11, 32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd6},  // R6 still a miss
    '{1'b0, 16'd9,  32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd3},  // R3
    '{1'b0, 16'd17, 32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd7},  // R7 fill
    '{1'b0, 16'd25, 32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd7},  // R7
    '{1'b0, 16'd33, 32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd7},  // R7
    '{1'b0, 16'd41, 32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd7},  // R7
    '{1'b0, 16'd49, 32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd7},  // R7 buffer full
    '{1'b0, 16'd57, 32'h0,         1'b0, 2'd1, 2'd0, 2'd1, 4'd8},  // R8 dirty victim
    '{1'b0, 16'd3,  32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd7},  // R7 first one evicted
    '{1'b0, 16'd15, 32'h0,         1'b0, 2'd1, 2'd0, 2'd0, 4'd7},  // R7 second evicted
    '{1'b1, 16'd3,  32'h4444_0003, 1'b0, 2'd0, 2'd0, 2'd0, 4'd5},  // R5
    '{1'b1, 16'd17, 32'h5555_0011, 1'b0, 2'd0, 2'd0, 2'd0, 4'd5}   // R5
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bit fb;
    int lat, edges, r0, w0, b0;
    string rq;
    rst_n = 1'b0; up_req_valid = 1'b0; up_req_wr = 1'b0; up_req_addr = '0;
    up_req_wdata = '0; up_rsp_ready = 1'b1; flush_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(up_req_ready && !up_rsp_valid && !dn_req_valid && !flush_done, "R1", "reset outputs",
        {60'd0, up_req_ready, up_rsp_valid, dn_req_valid, flush_done}, 64'h8);

    for (int i = 0; i < NV; i++) begin
      rq = $sformatf("R%0d row%0d", TBL[i].req, i);
      r0 = n_rd; w0 = n_wr; b0 = n_wb;
      do_op(TBL[i].wr, TBL[i].addr, TBL[i].wd, 0, rd, fb, lat);
      repeat (4) @(negedge clk);
      chk(n_rd - r0 == int'(TBL[i].drd) && n_wr - w0 == int'(TBL[i].dwr)
          && n_wb - b0 == int'(TBL[i].dwb), rq, "downstream rd/wr/wb",
          {32'(n_rd - r0), 16'(n_wr - w0), 16'(n_wb - b0)},
          {32'(TBL[i].drd), 16'(TBL[i].dwr), 16'(TBL[i].dwb)});
      if (TBL[i].wr) begin
        sw[TBL[i].addr[7:0]] = TBL[i].wd;
      end else begin
        chk(rd == sw[TBL[i].addr[7:0]], rq, "load data", 64'(rd), 64'(sw[TBL[i].addr[7:0]]));
        chk(fb == TBL[i].fb, rq, "served-by-buffer flag", 64'(fb), 64'(TBL[i].fb));
        if (TBL[i].req == 4'd4) chk(lat == 1, rq, "hit latency", 64'(lat), 64'd1);
      end
    end

    // R8 victim write-back contents
    chk(last_wb_addr == 16'd3 && last_wb_data == {32'h2222_0007, 32'hA000_0003}, "R8",
        "victim write-back", {last_wb_addr, last_wb_data[47:0]}, {16'd3, 48'h0007_A000_0003});

    // R10 flush wins over a same-cycle request
    @(negedge clk);
    up_req_valid = 1'b1; up_req_wr = 1'b0; up_req_addr = 16'd3; flush_start = 1'b1;
    #1;
    chk(!up_req_ready, "R10", "ready with flush_start", 64'(up_req_ready), 64'd0);
    b0 = n_wb; r0 = n_rd;
    @(posedge clk);
    @(negedge clk);
    up_req_valid = 1'b0; flush_start = 1'b0;
    chk(!up_req_ready, "R10", "ready during flush", 64'(up_req_ready), 64'd0);
    edges = 0;
    while (!flush_done && edges < 1000) begin @(negedge clk); edges++; end
    // R9 done timing and write-backs
    chk(edges == 8, "R9", "flush length", 64'(edges), 64'd8);
    repeat (2) @(negedge clk);
    chk(n_wb - b0 == 2, "R9", "flush write-backs", 64'(n_wb - b0), 64'd2);
    chk(mem[3] == 32'h4444_0003 && mem[17] == 32'h5555_0011, "R9", "written-back data",
        {mem[3], mem[17]}, {32'h4444_0003, 32'h5555_0011});
    chk(n_rd == r0 && !up_rsp_valid, "R10", "blocked request not taken",
        64'(n_rd - r0), 64'd0);
    // R9 entries invalid after flush
    r0 = n_rd;
    do_op(1'b0, 16'd3, 32'h0, 0, rd, fb, lat);
    repeat (3) @(negedge clk);
    chk(!fb && n_rd - r0 == 1 && rd == 32'h4444_0003, "R9", "load after flush",
        {31'd0, fb, rd}, {32'd0, 32'h4444_0003});

    // R11 held response on a hit
    do_op(1'b0, 16'd7, 32'h0, 3, rd, fb, lat);
    chk(rd == 32'h2222_0007 && fb, "R11", "held hit data", {31'd0, fb, rd}, {32'd1, 32'h2222_0007});

    // R11 downstream back-pressure
    bp = 1'b1;
    do_op(1'b0, 16'd65, 32'h0, 0, rd, fb, lat);
    chk(rd == 32'hA000_0041 && !fb, "R11", "miss under stall", 64'(rd), 64'hA000_0041);
    do_op(1'b1, 16'd65, 32'h6666_0041, 0, rd, fb, lat);
    repeat (3) @(negedge clk);
    b0 = n_wb;
    run_flush(edges);
    repeat (4) @(negedge clk);
    chk(n_wb - b0 == 1 && mem[65] == 32'h6666_0041, "R11", "flush under stall",
        {32'(n_wb - b0), mem[65]}, {32'd1, 32'h6666_0041});
    chk(edges >= 8 && edges < 1000, "R9", "stalled flush completes", 64'(edges), 64'd9);
    bp = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule